// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Synchronized Ready and Fill Flags

This block moves 36-bit words in one direction between two unrelated clocks. The producer side is clocked by `wclk` and offers a word on each edge where its access decode says "write to the FIFO". The consumer side is clocked by `rclk` and takes the word held in a dedicated output register on each edge where its access decode says "read from the FIFO". Each side decodes its access from four pins: an active-low port select, a direction bit, a side-channel select that must be low to reach the FIFO, and an enable.

The producer sees a single ready flag that drops when storage is full. The consumer sees a valid flag for the output register and a fill flag that rises once the storage behind the output register holds more words than a fixed offset. Pointers cross between clocks in Gray code through two-flop synchronizers. Because of this, every flag that reacts to the other side changes a fixed number of local edges after the event, with one extra edge possible when the two clock edges nearly coincide.

The output register is loaded automatically whenever it is empty and storage has a word. The total capacity is therefore the storage depth plus one word.

Top module: `bfifo_bridge`

## Requirements
- R1: A word is written on a rising `wclk` edge only when `wr_sel_n`=0, `wr_dir`=0, `wr_mbox`=0, `wr_en`=1 and `wr_ready`=1. Any other pin combination writes nothing.
- R2: A read is accepted on a rising `rclk` edge only when `rd_sel_n`=0, `rd_dir`=1, `rd_mbox`=0, `rd_en`=1 and `rd_valid`=1. Any other combination leaves `rd_data` and `rd_valid` unchanged.
- R3: `wr_ready` is low exactly when storage holds DEPTH words (DEPTH+1 counting the output register). Writes attempted while it is low are dropped, and no word is lost or duplicated.
- R4: After a read frees a storage location in a full FIFO, `wr_ready` rises on the second rising `wclk` edge after that read, or on the third.
- R5: `rd_above_mark` is low while storage behind the output register holds at most OFFSET words. It rises on the second rising `rclk` edge after the write that brings that count to OFFSET+1, or on the third.
- R6: A write into a completely empty FIFO sets `rd_valid` on the third rising `rclk` edge after the write, or on the fourth, with that word on `rd_data`.
- R7: `rd_data` holds its word until a read is accepted. An accepted read loads the next stored word on the same edge. If none is stored, `rd_valid` falls and `rd_data` keeps the word just read.
- R8: A read attempted while `rd_valid` is low is ignored and does not consume a later word.
- R9: While `rst_n` is low and after its release, `wr_ready`=1, `rd_valid`=0 and `rd_above_mark`=0 until words are written.
- R10: Words leave in the order they were written, and the read pointer never passes the synchronized write pointer.
- R11: Each Gray-coded pointer changes by at most one bit per local clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| rclk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_sel_n | input | 1 | Producer port select, active low |
| wr_dir | input | 1 | Producer direction, 0 selects write |
| wr_mbox | input | 1 | Producer side-channel select, must be 0 for FIFO access |
| wr_en | input | 1 | Producer access enable |
| wr_data | input | 36 | Word to store |
| wr_ready | output | 1 | High while storage has a free location |
| rd_sel_n | input | 1 | Consumer port select, active low |
| rd_dir | input | 1 | Consumer direction, 1 selects read |
| rd_mbox | input | 1 | Consumer side-channel select, must be 0 for FIFO access |
| rd_en | input | 1 | Consumer access enable |
| rd_data | output | 36 | Output register contents |
| rd_valid | output | 1 | High while the output register holds an unread word |
| rd_above_mark | output | 1 | High while storage holds more than OFFSET words |

## Verification
The bench builds the block with its default values: DEPTH of 256 words and an OFFSET of 8. With these, a full condition is reached after 257 accepted writes, and the fill flag threshold sits at nine stored words, so both boundaries are exercised directly. The producer clock runs at 10 ns and the consumer clock at 13 ns with a phase offset, so the relative edge positions drift across the run. Each cross-domain latency is measured in local edges and compared against the nominal value or one more.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  localparam int unsigned WORD_W = 36;

  typedef enum logic {
    PORT_DIR_WRITE = 1'b0,
    PORT_DIR_READ  = 1'b1
  } port_dir_e;

  // FIFO access: select low, matching direction, side channel off, enabled
  function automatic logic port_hit(input logic sel_n, input logic dir,
                                    input logic mbox, input logic en,
                                    input port_dir_e want);
    return !sel_n && (dir == logic'(want)) && !mbox && en;
  endfunction

endpackage

// File: rtl/bfifo_rst_sync.sv
module bfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/bfifo_ptr_sync.sv
module bfifo_ptr_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/bfifo_wr_side.sv
module bfifo_wr_side
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          dir,
  input  logic          mbox,
  input  logic          en,
  input  logic [AW:0]   rgray_s,
  output logic          fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          ready
);

  localparam int unsigned PW = AW + 1;
  localparam logic [AW:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, fill;
  logic        full;

  always_comb begin
    rbin_s  = g2b(rgray_s);
    fill    = wbin_q - rbin_s;
    full    = (fill == FULL_LVL);
    fire    = port_hit(sel_n, dir, mbox, en, PORT_DIR_WRITE) && !full;
    wbin_d  = wbin_q + {{AW{1'b0}}, 1'b1};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (fire) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign ready = !full;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (wbin_q - rbin_s) <= FULL_LVL); // R3
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(wgray_q ^ $past(wgray_q)) <= 1); // R11

endmodule

// File: rtl/bfifo_rd_side.sv
module bfifo_rd_side
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned DW     = WORD_W,
  parameter int unsigned OFFSET = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          dir,
  input  logic          mbox,
  input  logic          en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          above
);

  localparam int unsigned PW = AW + 1;
  localparam logic [AW:0] MARK  = PW'(OFFSET);
  localparam logic [AW:0] LIMIT = PW'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, avail;
  logic [DW-1:0] data_q;
  logic          valid_q, valid_d, fire, load, has_word;

  always_comb begin
    wbin_s   = g2b(wgray_s);
    avail    = wbin_s - rbin_q;
    has_word = (avail != '0);
    fire     = port_hit(sel_n, dir, mbox, en, PORT_DIR_READ) && valid_q;
    load     = has_word && (!valid_q || fire);
    valid_d  = load || (valid_q && !fire);
    rbin_d   = rbin_q + {{AW{1'b0}}, 1'b1};
    rgray_d  = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
    end else if (load) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      data_q  <= mem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             valid_q <= 1'b0;
    else if (load || fire)  valid_q <= valid_d;
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
  assign data  = data_q;
  assign valid = valid_q;
  assign above = (avail > MARK);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (wbin_s - rbin_q) <= LIMIT); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (valid_q && !fire) |=> (valid_q && $stable(data_q))); // R7
  AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n) above |=> valid_q); // R5
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(rgray_q ^ $past(rgray_q)) <= 1); // R11

endmodule

// File: rtl/bfifo_bridge.sv
module bfifo_bridge
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned OFFSET = 8,
  parameter int unsigned DW     = WORD_W
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_sel_n,
  input  logic          wr_dir,
  input  logic          wr_mbox,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_sel_n,
  input  logic          rd_dir,
  input  logic          rd_mbox,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_above_mark
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic          w_srst_n, r_srst_n, wr_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] store_q;

  bfifo_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .srst_n(w_srst_n));
  bfifo_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .srst_n(r_srst_n));

  bfifo_ptr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(r_srst_n), .d(wgray), .q(wgray_s));
  bfifo_ptr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(w_srst_n), .d(rgray), .q(rgray_s));

  bfifo_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(wclk), .rst_n(w_srst_n),
    .sel_n(wr_sel_n), .dir(wr_dir), .mbox(wr_mbox), .en(wr_en),
    .rgray_s(rgray_s), .fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .ready(wr_ready)
  );

  always_ff @(posedge wclk) begin
    if (wr_fire) store[waddr] <= wr_data;
  end

  assign store_q = store[raddr];

  bfifo_rd_side #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFFSET(OFFSET)) u_rd (
    .clk(rclk), .rst_n(r_srst_n),
    .sel_n(rd_sel_n), .dir(rd_dir), .mbox(rd_mbox), .en(rd_en),
    .wgray_s(wgray_s), .mem_q(store_q), .raddr(raddr), .rgray(rgray),
    .data(rd_data), .valid(rd_valid), .above(rd_above_mark)
  );

endmodule

// File: tb/bfifo_bridge_tb_top.sv
`timescale 1ns/1ps
module bfifo_bridge_tb_top;

  localparam int DEPTH  = 256;
  localparam int OFFSET = 8;
  localparam logic [35:0] BAD = 36'hF_DEAD_BEEF;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_sel_n = 1'b1, wr_dir = 1'b0, wr_mbox = 1'b0, wr_en = 1'b0;
  logic rd_sel_n = 1'b1, rd_dir = 1'b0, rd_mbox = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic wr_ready, rd_valid, rd_above_mark;

  int n_chk = 0, n_fail = 0, next_wr = 0, next_rd = 0;

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #6.5 rclk = ~rclk;
  end

  bfifo_bridge #(.DEPTH(DEPTH), .OFFSET(OFFSET)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_sel_n(wr_sel_n), .wr_dir(wr_dir), .wr_mbox(wr_mbox), .wr_en(wr_en),
    .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_sel_n(rd_sel_n), .rd_dir(rd_dir), .rd_mbox(rd_mbox), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_above_mark(rd_above_mark)
  );

  function automatic logic [35:0] seq(input int k);
    return 36'h5_0000_0000 | 36'(k * 37 + 1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_drive(input logic s, input logic d, input logic m, input logic e, input logic [35:0] v);
    @(negedge wclk);
    wr_sel_n = s; wr_dir = d; wr_mbox = m; wr_en = e; wr_data = v;
    @(posedge wclk);
    wr_sel_n <= 1'b1; wr_dir <= 1'b0; wr_mbox <= 1'b0; wr_en <= 1'b0;
  endtask

  task automatic rd_drive(input logic s, input logic d, input logic m, input logic e);
    @(negedge rclk);
    rd_sel_n = s; rd_dir = d; rd_mbox = m; rd_en = e;
    @(posedge rclk);
    rd_sel_n <= 1'b1; rd_dir <= 1'b0; rd_mbox <= 1'b0; rd_en <= 1'b0;
  endtask

  task automatic wr_word(input logic [35:0] v);
    wr_drive(1'b0, 1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic rd_word();
    rd_drive(1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic drain(input int expect_n);
    int got = 0;
    for (int i = 0; i < DEPTH + 8; i++) begin
      @(negedge rclk);
      if (!rd_valid) break;
      chk("R10 order", rd_data, seq(next_rd));
      next_rd++; got++;
      rd_sel_n = 1'b0; rd_dir = 1'b1; rd_en = 1'b1;
      @(posedge rclk);
      rd_sel_n <= 1'b1; rd_dir <= 1'b0; rd_en <= 1'b0;
    end
    chk("R10 drained count", got, expect_n);
    repeat (10) @(posedge rclk);
    @(negedge rclk);
    chk("R8 empty after drain", rd_valid, 1'b0);
  endtask

  task automatic t_reset();
    #47;
    chk("R9 ready in reset", wr_ready, 1'b1);
    chk("R9 valid in reset", rd_valid, 1'b0);
    chk("R9 mark in reset", rd_above_mark, 1'b0);
    #56 rst_n = 1'b1;
    repeat (6) @(posedge rclk);
    @(negedge rclk);
    chk("R9 valid after release", rd_valid, 1'b0);
    chk("R9 ready after release", wr_ready, 1'b1);
  endtask

  task automatic t_decode_write();
    int n = 0;
    wr_drive(1'b1, 1'b0, 1'b0, 1'b1, BAD);
    wr_drive(1'b0, 1'b1, 1'b0, 1'b1, BAD);
    wr_drive(1'b0, 1'b0, 1'b1, 1'b1, BAD);
    wr_drive(1'b0, 1'b0, 1'b0, 1'b0, BAD);
    repeat (10) @(posedge rclk);
    @(negedge rclk);
    chk("R1 stray writes stored nothing", rd_valid, 1'b0);
    wr_word(seq(next_wr)); next_wr++;
    for (int k = 0; k < 8; k++) begin
      @(posedge rclk); n++; #1;
      if (rd_valid) break;
    end
    chk_rng("R6 valid latency", n, 3, 4);
    chk("R6 first word", rd_data, seq(next_rd));
  endtask

  task automatic t_decode_read();
    wr_word(seq(next_wr)); next_wr++;
    repeat (10) @(posedge rclk);
    rd_drive(1'b1, 1'b1, 1'b0, 1'b1);
    rd_drive(1'b0, 1'b0, 1'b0, 1'b1);
    rd_drive(1'b0, 1'b1, 1'b1, 1'b1);
    rd_drive(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge rclk);
    chk("R2 stray reads keep valid", rd_valid, 1'b1);
    chk("R2 stray reads keep data", rd_data, seq(next_rd));
    rd_word(); next_rd++;
    @(negedge rclk);
    chk("R7 next word loaded on read", rd_data, seq(next_rd));
    rd_word(); next_rd++;
    @(negedge rclk);
    chk("R7 valid drops when empty", rd_valid, 1'b0);
    chk("R7 last word held", rd_data, seq(next_rd - 1));
    rd_word();
    wr_word(seq(next_wr)); next_wr++;
    repeat (10) @(posedge rclk);
    @(negedge rclk);
    chk("R8 later word survives", rd_valid, 1'b1);
    chk("R8 later word value", rd_data, seq(next_rd));
    rd_word(); next_rd++;
    repeat (10) @(posedge rclk);
    @(negedge rclk);
    chk("R8 no phantom word", rd_valid, 1'b0);
  endtask

  task automatic t_mark();
    int n = 0;
    for (int k = 0; k < OFFSET + 1; k++) begin
      wr_word(seq(next_wr)); next_wr++;
    end
    repeat (12) @(posedge rclk);
    @(negedge rclk);
    chk("R5 mark low at offset", rd_above_mark, 1'b0);
    wr_word(seq(next_wr)); next_wr++;
    for (int k = 0; k < 6; k++) begin
      @(posedge rclk); n++; #1;
      if (rd_above_mark) break;
    end
    chk_rng("R5 mark latency", n, 2, 3);
    drain(OFFSET + 2);
    chk("R5 mark low after drain", rd_above_mark, 1'b0);
  endtask

  task automatic t_full();
    int cnt = 0;
    int n = 0;
    wr_word(seq(next_wr)); next_wr++;
    repeat (10) @(posedge rclk);
    for (int i = 0; i < DEPTH + 8; i++) begin
      @(negedge wclk);
      if (!wr_ready) break;
      wr_sel_n = 1'b0; wr_dir = 1'b0; wr_mbox = 1'b0; wr_en = 1'b1;
      wr_data = seq(next_wr);
      @(posedge wclk);
      wr_en <= 1'b0; wr_sel_n <= 1'b1;
      next_wr++; cnt++;
    end
    chk("R3 writes until full", cnt, DEPTH);
    for (int k = 0; k < 3; k++) wr_word(BAD);
    repeat (6) @(negedge wclk);
    chk("R3 ready stays low", wr_ready, 1'b0);
    @(negedge rclk);
    chk("R10 head word", rd_data, seq(next_rd));
    rd_word(); next_rd++;
    for (int k = 0; k < 6; k++) begin
      @(posedge wclk); n++; #1;
      if (wr_ready) break;
    end
    chk_rng("R4 ready latency", n, 2, 3);
    drain(DEPTH);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_decode_write();
    t_decode_read();
    t_mark();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule